// File: doc/BRIEF.md
# Every-nth enabled lane decimator

This block takes a vector of lane enables and a runtime modulus, and returns a mask that keeps only a regular subset of the enabled lanes: every n-th one, counted in scan order. It is used wherever a set of active lanes has to be thinned out evenly. Typical cases are taking one sample in n from a sparse valid vector, or picking group leaders among active requesters.

The serial picture is a counter that walks the lanes and fires on a fixed phase of its count. The block does not step through the lanes like that. It computes each lane's result directly. Each lane holds a running count of enabled lanes, measured from the scan's starting end up to and including itself. The modulus is decoded once into a set of equality flags. A shared table then records, for every possible count, whether that count minus the phase is a multiple of the modulus. Each lane looks up its own count in that table and ANDs the result with its enable.

Two compile-time options fix the behaviour. The scan direction runs from the least or from the most significant lane. The phase (offset) decides between marking the n-th, 2n-th and later enabled lanes, and marking the first enabled lane of each group of n. A further option places a register on the output. The widths and options are checked when the design is elaborated: the lane count must be 4 to 62, the modulus must be at least 2 bits wide, and each option must be 0 or 1.

Top module: `decim_every_nth`

## Requirements
- R1: A mask bit is only ever set in a lane whose enable bit is set.
- R2: When the modulus is 0, the whole mask is 0.
- R3: With MSB_FIRST=0, the count of lane i is the number of enable bits set among lanes 0 to i, inclusive.
- R4: With MSB_FIRST=1, the count of lane i is the number of enable bits set among lanes i to W-1, inclusive.
- R5: With OFFSET=0, an enabled lane is marked when its count is a multiple of the modulus. This marks the n-th, 2n-th and later enabled lanes.
- R6: With OFFSET=1, an enabled lane is marked when its count minus 1 is a multiple of the modulus. As a result, the first enabled lane in scan order is marked whenever the modulus is nonzero.
- R7: With OFFSET=0 and a modulus greater than W, the mask is all zero.
- R8: A modulus of 1 makes the mask equal to the enable vector, for either offset.
- R9: With REG_OUT=1, the mask appears one clock after its inputs, and an active-low asynchronous reset clears it to 0. With REG_OUT=0, the mask follows the inputs combinationally.
- R10: For a nonzero modulus n and P enabled lanes, the number of marked lanes is floor(P/n) with OFFSET=0 and ceil(P/n) with OFFSET=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_vec | input | W | Lane enable vector |
| modulus | input | NW | Decimation modulus n (0 disables all marks) |
| mark | output | W | Lanes selected as every n-th enabled lane |

## Verification
The modulus is swept from 0 to W+1 and then set to its largest code. For each value, the bench applies a fixed family of enable vectors:
- All-zero and all-one vectors probe the empty and full counts.
- Alternating patterns separate the two scan directions, because the counts of a given lane differ depending on the end the scan starts from.
- One-hot vectors isolate the first-lane rule that tells the two offsets apart.
- Pseudo-random fills exercise carries across the count.

The moduli 0, 1 and values above W each probe a degenerate divisibility case. All four direction and offset combinations are compared against a serial counter model on every clock.

// File: rtl/decim_pkg.sv
`timescale 1ns/1ps
package decim_pkg;

   // Width of a running count that must reach w.
   function automatic int cnt_bits(input int w);
      return $clog2(w + 1);
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Scan-order position s mapped onto a lane index.
   function automatic int lane_of(input int s, input int w, input bit from_top);
      return from_top ? (w - 1 - s) : s;
   endfunction

endpackage

// File: rtl/decim_prefix_count.sv
`timescale 1ns/1ps
module decim_prefix_count
   import decim_pkg::*;
#(
   parameter int W         = 16,
   parameter int CW        = 5,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic [W-1:0]         en_i,
   output logic [W-1:0][CW-1:0] cnt_o
);

   // Inclusive running count in scan order. A single ordered loop keeps the
   // accumulation free of self-referencing nets. The adder chain is written
   // linearly so that synthesis can rebuild it as a prefix tree.
   if (MSB_FIRST) begin : g_from_top
      always_comb begin
         logic [CW-1:0] acc;
         acc = '0;
         for (int s = 0; s < W; s++) begin
            acc = acc + CW'(en_i[W-1-s]);
            cnt_o[W-1-s] = acc;
         end
      end
   end else begin : g_from_bottom
      always_comb begin
         logic [CW-1:0] acc;
         acc = '0;
         for (int s = 0; s < W; s++) begin
            acc = acc + CW'(en_i[s]);
            cnt_o[s] = acc;
         end
      end
   end

endmodule

// File: rtl/decim_div_table.sv
`timescale 1ns/1ps
module decim_div_table
   import decim_pkg::*;
#(
   parameter int W      = 16,
   parameter int NW     = 5,
   parameter int CW     = 5,
   parameter int OFFSET = 0
) (
   input  logic [NW-1:0]      mod_i,
   output logic [2**CW-1:0]   div_o
);

   localparam int CMPW = max_int(NW, CW);
   localparam int TBL  = 2 ** CW;

   logic [CMPW-1:0] mod_ext;
   logic [W:1]      is_d;

   assign mod_ext = CMPW'(mod_i);

   // One equality flag per candidate divisor.
   for (genvar d = 1; d <= W; d++) begin : g_dec
      assign is_d[d] = (mod_ext == CMPW'(d));
   end

   // One table entry per possible count value.
   for (genvar k = 0; k < TBL; k++) begin : g_tab
      if (k == 0) begin : g_zero
         // Count 0 only occurs on a disabled lane, which the AND in the
         // lane select masks out.
         assign div_o[k] = 1'b1;
      end else if (k > W) begin : g_out
         assign div_o[k] = 1'b0;
      end else begin : g_live
         localparam int T = k - OFFSET;
         if (T == 0) begin : g_any
            // A target of 0 is a multiple of every nonzero modulus.
            assign div_o[k] = |mod_i;
         end else begin : g_sum
            logic hit;
            always_comb begin
               hit = 1'b0;
               for (int d = 1; d <= W; d++) begin
                  if ((d <= T) && ((T % d) == 0)) hit = hit | is_d[d];
               end
            end
            assign div_o[k] = hit;
         end
      end
   end

endmodule

// File: rtl/decim_lane_select.sv
`timescale 1ns/1ps
module decim_lane_select #(
   parameter int W  = 16,
   parameter int CW = 5
) (
   input  logic [W-1:0]         en_i,
   input  logic [W-1:0][CW-1:0] cnt_i,
   input  logic [2**CW-1:0]     div_i,
   output logic [W-1:0]         mark_o
);

   // Each lane reads the shared table at its own count.
   for (genvar i = 0; i < W; i++) begin : g_lane
      assign mark_o[i] = en_i[i] & div_i[cnt_i[i]];
   end

endmodule

// File: rtl/decim_every_nth.sv
`timescale 1ns/1ps
module decim_every_nth
   import decim_pkg::*;
#(
   parameter int W         = 16,
   parameter int NW        = 5,
   parameter bit MSB_FIRST = 1'b0,
   parameter int OFFSET    = 0,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  en_vec,
   input  logic [NW-1:0] modulus,
   output logic [W-1:0]  mark
);

   localparam int CW  = cnt_bits(W);
   localparam int TBL = 2 ** CW;

   // Elaboration-time parameter checks.
   if (W < 4 || W > 62) begin : g_bad_w
      $error("decim_every_nth: W must be within 4..62");
   end
   if (NW < 2) begin : g_bad_nw
      $error("decim_every_nth: modulus needs at least 2 bits");
   end
   if (OFFSET != 0 && OFFSET != 1) begin : g_bad_off
      $error("decim_every_nth: OFFSET must be 0 or 1");
   end

   logic [W-1:0][CW-1:0] lane_cnt;
   logic [TBL-1:0]       div_tab;
   logic [W-1:0]         mark_c;

   decim_prefix_count #(
      .W(W), .CW(CW), .MSB_FIRST(MSB_FIRST)
   ) u_count (
      .en_i  (en_vec),
      .cnt_o (lane_cnt)
   );

   decim_div_table #(
      .W(W), .NW(NW), .CW(CW), .OFFSET(OFFSET)
   ) u_table (
      .mod_i (modulus),
      .div_o (div_tab)
   );

   decim_lane_select #(
      .W(W), .CW(CW)
   ) u_select (
      .en_i   (en_vec),
      .cnt_i  (lane_cnt),
      .div_i  (div_tab),
      .mark_o (mark_c)
   );

   if (REG_OUT) begin : g_reg
      logic [W-1:0] mark_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mark_q <= '0;
         else        mark_q <= mark_c;
      end
      assign mark = mark_q;

      // R9: the register carries the previous cycle's result
      p_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (mark == $past(mark_c)))
         else $error("p_pipe_r9");
   end else begin : g_comb
      assign mark = mark_c;
   end

   // Expected number of marks, from the enable total and the modulus.
   int pop_en;
   int want_marks;
   always_comb begin
      pop_en = $countones(en_vec);
      if (modulus == '0)    want_marks = 0;
      else if (OFFSET == 0) want_marks = pop_en / int'(modulus);
      else                  want_marks = (pop_en + int'(modulus) - 1) / int'(modulus);
   end

   p_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_c & ~en_vec) == '0)
      else $error("p_subset_r1");

   p_zero_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (modulus == '0) |-> (mark_c == '0))
      else $error("p_zero_mod_r2");

   p_unit_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (modulus == NW'(1)) |-> (mark_c == en_vec))
      else $error("p_unit_mod_r8");

   p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mark_c) == want_marks)
      else $error("p_count_r10");

   if (OFFSET == 0) begin : g_chk_off0
      p_wide_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(modulus) > W) |-> (mark_c == '0))
         else $error("p_wide_mod_r7");
   end else begin : g_chk_off1
      p_first_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ((modulus != '0) && (en_vec != '0)) |-> (mark_c != '0))
         else $error("p_first_mark_r6");
   end

endmodule

// File: tb/decim_every_nth_tb.sv
`timescale 1ns/1ps
module decim_every_nth_tb;

   localparam int W    = 16;
   localparam int NW   = 5;
   localparam int HALF = 10;

   logic clk = 1'b0;
   always #HALF clk = ~clk;

   logic          rst_n;
   logic [W-1:0]  en_vec;
   logic [NW-1:0] modulus;
   logic [W-1:0]  mk_lsb0, mk_msb0, mk_lsb1, mk_msb1, mk_comb;

   decim_every_nth #(.W(W), .NW(NW), .MSB_FIRST(1'b0), .OFFSET(0), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .modulus(modulus), .mark(mk_lsb0));
   decim_every_nth #(.W(W), .NW(NW), .MSB_FIRST(1'b1), .OFFSET(0), .REG_OUT(1'b1)) u_dut_msb0 (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .modulus(modulus), .mark(mk_msb0));
   decim_every_nth #(.W(W), .NW(NW), .MSB_FIRST(1'b0), .OFFSET(1), .REG_OUT(1'b1)) u_dut_lsb1 (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .modulus(modulus), .mark(mk_lsb1));
   decim_every_nth #(.W(W), .NW(NW), .MSB_FIRST(1'b1), .OFFSET(1), .REG_OUT(1'b1)) u_dut_msb1 (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .modulus(modulus), .mark(mk_msb1));
   decim_every_nth #(.W(W), .NW(NW), .MSB_FIRST(1'b0), .OFFSET(0), .REG_OUT(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .en_vec(en_vec), .modulus(modulus), .mark(mk_comb));

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [W-1:0] pe;
   int           pn;
   bit           have_prev = 1'b0;

   // Serial reference: a counter walked lane by lane in scan order.
   function automatic logic [W-1:0] model(logic [W-1:0] e, int n, bit msb, bit off);
      logic [W-1:0] r;
      int run;
      r   = '0;
      run = 0;
      if (n == 0) return r;
      for (int s = 0; s < W; s++) begin
         int i;
         i = msb ? (W - 1 - s) : s;
         if (e[i]) begin
            if (off) begin
               if (run == 0) r[i] = 1'b1;
               run = (run + 1 == n) ? 0 : run + 1;
            end else begin
               if (run == n - 1) begin
                  r[i] = 1'b1;
                  run  = 0;
               end else begin
                  run = run + 1;
               end
            end
         end
      end
      return r;
   endfunction

   function automatic string tag(int n, bit msb, bit off);
      if (n == 0)              return "R2";
      if (n == 1)              return "R8";
      if (!off && n > W)       return "R7";
      return $sformatf("%s %s R9", msb ? "R4" : "R3", off ? "R6" : "R5");
   endfunction

   task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h (en=%h n=%0d)", req, got, exp, pe, pn);
      end
   endtask

   task automatic check_regs();
      int p;
      p = $countones(pe);
      chk(tag(pn, 1'b0, 1'b0), mk_lsb0, model(pe, pn, 1'b0, 1'b0));
      chk(tag(pn, 1'b1, 1'b0), mk_msb0, model(pe, pn, 1'b1, 1'b0));
      chk(tag(pn, 1'b0, 1'b1), mk_lsb1, model(pe, pn, 1'b0, 1'b1));
      chk(tag(pn, 1'b1, 1'b1), mk_msb1, model(pe, pn, 1'b1, 1'b1));
      chk("R1", mk_msb1 & ~pe, '0);
      if (pn != 0) begin
         chk("R10 floor", W'($countones(mk_msb0)), W'(p / pn));
         chk("R10 ceil",  W'($countones(mk_lsb1)), W'((p + pn - 1) / pn));
      end
   endtask

   task automatic step(logic [W-1:0] e, int n);
      @(negedge clk);
      if (have_prev) check_regs();
      en_vec  = e;
      modulus = NW'(n);
      #1;
      pe = e;
      pn = n;
      chk("R9 comb", mk_comb, model(e, n, 1'b0, 1'b0));
      have_prev = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      logic [31:0] lfsr;
      lfsr    = 32'h2468ace1;
      rst_n   = 1'b0;
      en_vec  = '1;
      modulus = NW'(2);
      pe      = '1;
      pn      = 2;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset holds every registered mask at zero despite live inputs
      chk("R9 reset", mk_lsb0, '0);
      chk("R9 reset", mk_msb0, '0);
      chk("R9 reset", mk_lsb1, '0);
      chk("R9 reset", mk_msb1, '0);
      rst_n = 1'b1;

      for (int m = 0; m <= W + 2; m++) begin
         int nv;
         nv = (m == W + 2) ? (2 ** NW - 1) : m;
         step('0, nv);
         step('1, nv);
         step({(W/2){2'b01}}, nv);
         step({(W/2){2'b10}}, nv);
         for (int b = 0; b < W; b++) step(W'(1) << b, nv);
         for (int r = 0; r < 12; r++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[W-1:0], nv);
         end
      end
      @(negedge clk);
      check_regs();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(2 * HALF * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual unfinished expected finished");
         summary();
         $finish;
      end
   end

endmodule